// File: doc/BRIEF.md
# Exception Return Status Controller

This block keeps a processor's status word, together with the copies of it that are saved when an exception is taken. It also keeps one exception-address register for each register set. The core has one normal register set (set 0) and a configurable number of shadow sets.

When an exception is taken, the block saves the status word and the faulting PC. If the handler is given a dedicated shadow set, the block also switches to that set. A single return strobe undoes the switch: the status word is rebuilt from the copy that belongs to the active set, and one cycle later fetch receives the resume address together with a valid flag.

Interrupted code therefore gets its previous register set back without any software save. The handler's exception-temporary register is not preserved by hardware; it is scratch. A return may take the core out of NMI mode, but it can never put the core into NMI mode. Apart from entries and returns, the interrupt-enable and user-mode bits can also be written directly by the core.

Top module: `trap_status_unit`

## Requirements
- R1: After reset, interrupt enable, user mode, current set, previous set and NMI mode are all 0, and redirectValid is 0.
- R2: An accepted entry with target set 0 copies status into the primary saved copy and the PC into the set-0 address register. It clears interrupt enable and user mode, and leaves the current and previous set fields unchanged.
- R3: An accepted entry with target set t, where 1 <= t <= NUM_SHADOW, copies status into set t's shadow copy and the PC into set t's address register. It sets previous set to the old current set and current set to t, and clears interrupt enable and user mode.
- R4: An entry with enterNmi=1 sets NMI mode. An entry with enterNmi=0 leaves NMI mode as it was.
- R5: A return while current set is 0 reloads every status field from the primary saved copy, with NMI handled as in R8.
- R6: A return while current set is nonzero reloads status from that set's shadow copy, so the set that was active before the matching entry becomes current again.
- R7: redirectPc carries the address register of the set that was current before the return. redirectValid is 1 only in the cycle after an accepted return strobe.
- R8: After a return, NMI mode equals the saved copy's NMI bit ANDed with the NMI mode held before the return. A return can clear NMI mode but never set it.
- R9: While enterReq is high, a return strobe and a status write in the same cycle are ignored. No redirect follows, and status changes only as the entry dictates.
- R10: An entry whose target set exceeds NUM_SHADOW changes no status field, saved copy or address register.
- R11: Entries into different shadow sets nest. Returns unwind them in reverse order, each one restoring its own status and resume PC.
- R12: A status write with no entry and no return in the same cycle loads interrupt enable and user mode from wrIntEn and wrUser. The other fields are kept. A return in the same cycle takes priority over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enterReq | input | 1 | Exception entry request |
| enterPc | input | PC_W | Faulting PC to save |
| enterNmi | input | 1 | Entry is a non-maskable interrupt |
| enterSet | input | 3 | Target register set for the handler |
| retStrobe | input | 1 | Return-from-exception strobe |
| wrEn | input | 1 | Direct status write strobe |
| wrIntEn | input | 1 | Interrupt enable value to write |
| wrUser | input | 1 | User mode value to write |
| intEn | output | 1 | Status: interrupt enable |
| userMode | output | 1 | Status: user mode |
| curSet | output | 3 | Status: current register set |
| prevSet | output | 3 | Status: previous register set |
| nmiMode | output | 1 | Status: NMI mode |
| redirectValid | output | 1 | Resume address valid (one cycle per return) |
| redirectPc | output | PC_W | Resume address for fetch |

## Verification
The bench uses three shadow sets. It sweeps every combination of written interrupt enable and user mode, NMI flag and all eight encodings of the target set, and follows each entry with a return. This separates the primary copy from the shadow copies, and accepted targets from rejected ones.

Directed chains cover three nested shadow entries unwound in reverse order. A constructed state tests the NMI restriction: NMI mode is clear while the saved copy has NMI set, which tells an AND apart from a plain copy. The chains also cover simultaneous entry with return, write with return, and back-to-back returns.

A long pseudo-random mix of entries, returns, writes and idle cycles is then compared against a bench model on every cycle.

// File: rtl/trap_status_pkg.sv
package trap_status_pkg;

  localparam int SetFieldW = 3;
  localparam int MaxSets   = 8;

  typedef struct packed {
    logic                 nmi;
    logic [SetFieldW-1:0] prevSet;
    logic [SetFieldW-1:0] curSet;
    logic                 user;
    logic                 intEn;
  } statusT;

  typedef struct packed {
    logic                 doEnter;
    logic                 toShadow;
    logic [SetFieldW-1:0] tgtSet;
    logic                 setNmi;
    logic                 doReturn;
    logic                 doWrite;
    logic                 wrIntEn;
    logic                 wrUser;
  } ctrlStrobesT;

endpackage

// File: rtl/trap_status_ctrl.sv
module trap_status_ctrl
  import trap_status_pkg::*;
#(
  parameter int NUM_SHADOW = 3
) (
  input  logic                 enterReq,
  input  logic                 enterNmi,
  input  logic [SetFieldW-1:0] enterSet,
  input  logic                 retStrobe,
  input  logic                 wrEn,
  input  logic                 wrIntEn,
  input  logic                 wrUser,
  output ctrlStrobesT          strobes
);

  logic setInRange;

  // A target beyond the configured shadow sets discards the entry (R10).
  always_comb begin
    setInRange = (int'(enterSet) <= NUM_SHADOW);
  end

  // Priority: entry request, then return, then direct write (R9, R12).
  always_comb begin
    strobes          = '0;
    strobes.doEnter  = enterReq & setInRange;
    strobes.toShadow = (enterSet != '0);
    strobes.tgtSet   = enterSet;
    strobes.setNmi   = enterNmi;
    strobes.doReturn = retStrobe & ~enterReq;
    strobes.doWrite  = wrEn & ~enterReq & ~retStrobe;
    strobes.wrIntEn  = wrIntEn;
    strobes.wrUser   = wrUser;
  end

endmodule

// File: rtl/trap_status_dp.sv
module trap_status_dp
  import trap_status_pkg::*;
#(
  parameter int NUM_SHADOW = 3,
  parameter int PC_W       = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobesT     strobes,
  input  logic [PC_W-1:0] enterPc,
  output statusT          statusQ,
  output logic            redirectValidQ,
  output logic [PC_W-1:0] redirectPcQ
);

  localparam int NumSets = NUM_SHADOW + 1;

  statusT          statusD;
  statusT          primarySaved;
  statusT          shadowSaved [MaxSets];
  logic [PC_W-1:0] excAddr     [MaxSets];
  statusT          retSrc;

  // Return source is picked by the current set field before the return (R5, R6).
  always_comb begin
    retSrc = (statusQ.curSet == '0) ? primarySaved : shadowSaved[statusQ.curSet];
  end

  always_comb begin
    statusD = statusQ;
    if (strobes.doEnter) begin
      statusD.intEn = 1'b0;
      statusD.user  = 1'b0;
      statusD.nmi   = statusQ.nmi | strobes.setNmi;
      if (strobes.toShadow) begin
        statusD.prevSet = statusQ.curSet;
        statusD.curSet  = strobes.tgtSet;
      end
    end else if (strobes.doReturn) begin
      statusD     = retSrc;
      statusD.nmi = retSrc.nmi & statusQ.nmi;
    end else if (strobes.doWrite) begin
      statusD.intEn = strobes.wrIntEn;
      statusD.user  = strobes.wrUser;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ      <= '0;
      primarySaved <= '0;
    end else begin
      statusQ <= statusD;
      if (strobes.doEnter && !strobes.toShadow) begin
        primarySaved <= statusQ;
      end
    end
  end

  // Per-set storage: an address register for every set, a shadow copy for sets 1..N.
  for (genvar g = 0; g < MaxSets; g++) begin : g_set
    if (g < NumSets) begin : g_live
      always_ff @(posedge clk) begin
        if (!rstN) begin
          excAddr[g] <= '0;
        end else if (strobes.doEnter && strobes.tgtSet == SetFieldW'(g)) begin
          excAddr[g] <= enterPc;
        end
      end
      if (g > 0) begin : g_shadow
        always_ff @(posedge clk) begin
          if (!rstN) begin
            shadowSaved[g] <= '0;
          end else if (strobes.doEnter && strobes.tgtSet == SetFieldW'(g)) begin
            shadowSaved[g] <= statusQ;
          end
        end
      end else begin : g_noShadow
        assign shadowSaved[g] = '0;
      end
    end else begin : g_absent
      assign excAddr[g]     = '0;
      assign shadowSaved[g] = '0;
    end
  end

  // Resume address of the set active before the return, valid for one cycle (R7).
  always_ff @(posedge clk) begin
    if (!rstN) begin
      redirectValidQ <= 1'b0;
      redirectPcQ    <= '0;
    end else begin
      redirectValidQ <= strobes.doReturn;
      if (strobes.doReturn) begin
        redirectPcQ <= excAddr[statusQ.curSet];
      end
    end
  end

  a_r8_return_never_sets_nmi: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.doReturn && !statusQ.nmi) |=> !statusQ.nmi);

  a_r4_nmi_entry_sets_nmi: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.doEnter && strobes.setNmi) |=> statusQ.nmi);

  a_r2_entry_clears_pie_user: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doEnter |=> (!statusQ.intEn && !statusQ.user));

  a_r3_shadow_entry_switches_set: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.doEnter && strobes.toShadow) |=>
      (statusQ.curSet == $past(strobes.tgtSet) && statusQ.prevSet == $past(statusQ.curSet)));

  a_r10_set_in_range: assert property (@(posedge clk) disable iff (!rstN)
    int'(statusQ.curSet) <= NUM_SHADOW);

endmodule

// File: rtl/trap_status_unit.sv
module trap_status_unit
  import trap_status_pkg::*;
#(
  parameter int NUM_SHADOW = 3,
  parameter int PC_W       = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            enterReq,
  input  logic [PC_W-1:0] enterPc,
  input  logic            enterNmi,
  input  logic [2:0]      enterSet,
  input  logic            retStrobe,
  input  logic            wrEn,
  input  logic            wrIntEn,
  input  logic            wrUser,
  output logic            intEn,
  output logic            userMode,
  output logic [2:0]      curSet,
  output logic [2:0]      prevSet,
  output logic            nmiMode,
  output logic            redirectValid,
  output logic [PC_W-1:0] redirectPc
);

  ctrlStrobesT strobes;
  statusT      statusQ;

  trap_status_ctrl #(.NUM_SHADOW(NUM_SHADOW)) i_ctrl (
    .enterReq (enterReq),
    .enterNmi (enterNmi),
    .enterSet (enterSet),
    .retStrobe(retStrobe),
    .wrEn     (wrEn),
    .wrIntEn  (wrIntEn),
    .wrUser   (wrUser),
    .strobes  (strobes)
  );

  trap_status_dp #(.NUM_SHADOW(NUM_SHADOW), .PC_W(PC_W)) i_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .enterPc       (enterPc),
    .statusQ       (statusQ),
    .redirectValidQ(redirectValid),
    .redirectPcQ   (redirectPc)
  );

  assign intEn    = statusQ.intEn;
  assign userMode = statusQ.user;
  assign curSet   = statusQ.curSet;
  assign prevSet  = statusQ.prevSet;
  assign nmiMode  = statusQ.nmi;

  a_r9_entry_beats_return: assert property (@(posedge clk) disable iff (!rstN)
    (enterReq && retStrobe) |=> !redirectValid);

  a_r10_bad_target_no_effect: assert property (@(posedge clk) disable iff (!rstN)
    (enterReq && int'(enterSet) > NUM_SHADOW) |=>
      ($stable(curSet) && $stable(prevSet) && $stable(nmiMode) && $stable(intEn) && $stable(userMode)));

  a_r7_redirect_needs_return: assert property (@(posedge clk) disable iff (!rstN)
    !retStrobe |=> !redirectValid);

endmodule

// File: tb/test_trap_status_unit.sv
module test_trap_status_unit;
  import trap_status_pkg::*;

  localparam int NSH = 3;
  localparam int PCW = 32;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           enterReq = 1'b0;
  logic [PCW-1:0] enterPc = '0;
  logic           enterNmi = 1'b0;
  logic [2:0]     enterSet = '0;
  logic           retStrobe = 1'b0;
  logic           wrEn = 1'b0;
  logic           wrIntEn = 1'b0;
  logic           wrUser = 1'b0;
  logic           intEn, userMode, nmiMode, redirectValid;
  logic [2:0]     curSet, prevSet;
  logic [PCW-1:0] redirectPc;

  int total = 0;
  int bad = 0;

  statusT         mSt;
  statusT         mPri;
  statusT         mSh [8];
  logic [PCW-1:0] mEa [8];
  logic           mRv;
  logic [PCW-1:0] mRpc;
  logic [15:0]    lfsr = 16'hACE1;

  always #2 clk = ~clk;

  trap_status_unit #(.NUM_SHADOW(NSH), .PC_W(PCW)) i_trap_status_unit (
    .clk(clk), .rstN(rstN), .enterReq(enterReq), .enterPc(enterPc), .enterNmi(enterNmi),
    .enterSet(enterSet), .retStrobe(retStrobe), .wrEn(wrEn), .wrIntEn(wrIntEn), .wrUser(wrUser),
    .intEn(intEn), .userMode(userMode), .curSet(curSet), .prevSet(prevSet), .nmiMode(nmiMode),
    .redirectValid(redirectValid), .redirectPc(redirectPc)
  );

  task automatic checkOut(input string tag);
    statusT act;
    logic pcOk;
    act = '{nmi: nmiMode, prevSet: prevSet, curSet: curSet, user: userMode, intEn: intEn};
    pcOk = !mRv || (redirectPc == mRpc);
    total++;
    if (act !== mSt || redirectValid !== mRv || !pcOk) begin
      bad++;
      $display("FAIL %s: status=%b rv=%b pc=%h expected status=%b rv=%b pc=%h",
               tag, act, redirectValid, redirectPc, mSt, mRv, mRpc);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    mSt = '0; mPri = '0; mRv = 1'b0; mRpc = '0;
    for (int i = 0; i < 8; i++) begin
      mSh[i] = '0;
      mEa[i] = '0;
    end
  endtask

  task automatic step(input logic en, input logic [2:0] tset, input logic nmi,
                      input logic [PCW-1:0] pc, input logic ret, input logic wr,
                      input logic wi, input logic wu, input string tag);
    statusT src;
    @(negedge clk);
    enterReq = en; enterSet = tset; enterNmi = nmi; enterPc = pc;
    retStrobe = ret; wrEn = wr; wrIntEn = wi; wrUser = wu;
    mRv = 1'b0;
    if (en) begin
      if (int'(tset) <= NSH) begin
        mEa[tset] = pc;
        if (tset == 3'd0) begin
          mPri = mSt;
        end else begin
          mSh[tset] = mSt;
          mSt.prevSet = mSt.curSet;
          mSt.curSet = tset;
        end
        mSt.intEn = 1'b0;
        mSt.user = 1'b0;
        mSt.nmi = mSt.nmi | nmi;
      end
    end else if (ret) begin
      src = (mSt.curSet == 3'd0) ? mPri : mSh[mSt.curSet];
      mRv = 1'b1;
      mRpc = mEa[mSt.curSet];
      src.nmi = src.nmi & mSt.nmi;
      mSt = src;
    end else if (wr) begin
      mSt.intEn = wi;
      mSt.user = wu;
    end
    @(posedge clk);
    #1;
    enterReq = 1'b0; retStrobe = 1'b0; wrEn = 1'b0;
    checkOut(tag);
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    doReset();
    #1;
    checkOut("R1 reset state");

    // Sweep: written PIE/U, NMI flag and every target encoding, each followed by a return.
    for (int pw = 0; pw < 4; pw++) begin
      for (int nm = 0; nm < 2; nm++) begin
        for (int ts = 0; ts < 8; ts++) begin
          doReset();
          step(1'b0, 3'd0, 1'b0, '0, 1'b0, 1'b1, pw[0], pw[1], "R12 write");
          step(1'b1, 3'(ts), nm[0], 32'h1000_0000 + 32'(ts * 16 + pw * 4 + nm),
               1'b0, 1'b0, 1'b0, 1'b0,
               (ts > NSH) ? "R10 bad target" : (ts == 0 ? "R2 entry set0 R4" : "R3 entry shadow R4"));
          step(1'b0, 3'd0, 1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b0,
               (ts == 0 || ts > NSH) ? "R5 return primary R7" : "R6 return shadow R7");
          step(1'b0, 3'd0, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, "R7 redirect one cycle");
        end
      end
    end

    // Nested shadow entries unwound in reverse order.
    doReset();
    step(1'b0, 3'd0, 1'b0, '0, 1'b0, 1'b1, 1'b1, 1'b1, "R12 write");
    step(1'b1, 3'd1, 1'b0, 32'hA000_0001, 1'b0, 1'b0, 1'b0, 1'b0, "R11 nest1");
    step(1'b0, 3'd0, 1'b0, '0, 1'b0, 1'b1, 1'b1, 1'b0, "R12 write in handler");
    step(1'b1, 3'd2, 1'b0, 32'hA000_0002, 1'b0, 1'b0, 1'b0, 1'b0, "R11 nest2");
    step(1'b1, 3'd3, 1'b1, 32'hA000_0003, 1'b0, 1'b0, 1'b0, 1'b0, "R11 nest3 R4");
    step(1'b0, 3'd0, 1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b0, "R11 unwind3 R8");
    step(1'b0, 3'd0, 1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b0, "R11 unwind2 R7");
    step(1'b0, 3'd0, 1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b0, "R11 unwind1 R6");
    total++;
    if (curSet !== 3'd0 || intEn !== 1'b1 || userMode !== 1'b1 || redirectPc !== 32'hA000_0001) begin
      bad++;
      $display("FAIL R11: set=%0d pie=%b u=%b pc=%h expected set=0 pie=1 u=1 pc=a0000001",
               curSet, intEn, userMode, redirectPc);
    end

    // NMI clear while the saved primary copy has NMI set.
    doReset();
    step(1'b1, 3'd1, 1'b1, 32'hB000_0001, 1'b0, 1'b0, 1'b0, 1'b0, "R4 nmi entry");
    step(1'b1, 3'd0, 1'b0, 32'hB000_0002, 1'b0, 1'b0, 1'b0, 1'b0, "R2 entry in set1");
    step(1'b0, 3'd0, 1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b0, "R8 return clears nmi");
    step(1'b0, 3'd0, 1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b0, "R8 return keeps nmi clear");
    total++;
    if (nmiMode !== 1'b0 || curSet !== 3'd1) begin
      bad++;
      $display("FAIL R8: nmi=%b set=%0d expected nmi=0 set=1", nmiMode, curSet);
    end

    // Simultaneous requests.
    doReset();
    step(1'b1, 3'd2, 1'b0, 32'hC000_0002, 1'b0, 1'b0, 1'b0, 1'b0, "R3 entry");
    step(1'b1, 3'd1, 1'b0, 32'hC000_0001, 1'b1, 1'b1, 1'b1, 1'b1, "R9 entry beats return");
    step(1'b1, 3'd7, 1'b1, 32'hC000_0007, 1'b1, 1'b0, 1'b0, 1'b0, "R9 bad entry still blocks return R10");
    step(1'b0, 3'd0, 1'b0, '0, 1'b1, 1'b1, 1'b1, 1'b1, "R12 return beats write");
    step(1'b0, 3'd0, 1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b0, "R7 back-to-back return");

    // Pseudo-random mix.
    doReset();
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[2:0])
        3'd0, 3'd1: step(1'b1, lfsr[5:3], lfsr[6], {lfsr, lfsr}, lfsr[7], lfsr[8], lfsr[9], lfsr[10], "R11 random entry");
        3'd2, 3'd3, 3'd4: step(1'b0, 3'd0, 1'b0, '0, 1'b1, lfsr[8], lfsr[9], lfsr[10], "R11 random return");
        3'd5: step(1'b0, 3'd0, 1'b0, '0, 1'b0, 1'b1, lfsr[9], lfsr[10], "R12 random write");
        default: step(1'b0, 3'd0, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, "R7 random idle");
      endcase
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule